// File: doc/BRIEF.md
# Rename Buffer Pool with Register Mapping

This block gives an out-of-order integer datapath a shared pool of rename buffers. Buffers are handed out in program order as instructions issue, up to four per cycle. Every issued instruction takes one buffer, whether or not it writes a register. A table indexed by architectural register number records which buffer holds the newest value of each register. Operand lookups for the issuing group consult this table, and also see destinations claimed by earlier lanes of the same group.

Execution results arrive on several write ports: one per integer unit, and two for the load/store unit, so that a load-with-update can deliver its loaded data and its updated base address in the same cycle. The oldest buffers retire in order, up to four per cycle. Retirement stops at the first buffer whose result has not arrived. Retired values that have a destination are forwarded to an external architectural register file, and the buffers return to the pool.

The pool is a circular queue. `NUM_BUF` must be at least `ISSUE_W` and at least `RET_W`. The architectural register file lives outside the block and supplies, for each lookup lane, the current value of the looked-up register.

Top module: `rnm_unit`

## Requirements
- R1: After reset the pool is empty. A group of four receives tags 0,1,2,3. Every lookup returns ready with the architectural value supplied on `src_arch_data`, and `ret_cnt` is 0.
- R2: When a group of `iss_cnt` instructions is granted, lane i receives tag (tail + i) mod `NUM_BUF`. The tail then advances by `iss_cnt`, and lanes with `iss_has_dst` = 0 consume a tag like any other lane.
- R3: `iss_grant` is 0 when `iss_cnt` exceeds the number of free buffers, and in that case nothing is allocated. The next granted group starts at the same tag the refused group would have received.
- R4: A lookup of an unmapped register returns ready with `src_arch_data`. A register mapped to a buffer whose result has arrived returns ready with the buffer data. A register mapped to a buffer still waiting returns not ready, with `src_tag` set to that buffer.
- R5: Within one issue group, a lookup on lane i of a register that is the destination of a lane j < i, with j < `iss_cnt`, returns not ready with the tag of the highest such lane j.
- R6: Each integer write port and both load/store write ports may write distinct buffers in the same cycle. The values written become visible to lookups and to retirement in the next cycle.
- R7: In each cycle, retirement takes the longest run of completed buffers starting at the oldest, capped at `RET_W`. `ret_cnt` gives the length of the run. For lane j of the run, `ret_we[j]` is 1 only if that buffer has a destination, and `ret_areg`/`ret_data` carry the register and value, oldest first. Retired buffers are freed at the next clock edge.
- R8: Freed buffers are counted as free from the cycle after retirement, so a group that fits into the freed space is granted.
- R9: When a buffer retires and the table still maps its destination to that buffer, the mapping is cleared, and later lookups return `src_arch_data`. If the register has been remapped to a newer buffer, the newer mapping stays.
- R10: When several lanes of one group write the same register, the table afterwards maps it to the buffer of the highest such lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_cnt | input | $clog2(ISSUE_W+1) | Number of instructions requesting issue (lanes 0..iss_cnt-1) |
| iss_has_dst | input | ISSUE_W | Per lane: instruction writes a register |
| iss_dst | input | ISSUE_W*AW | Per lane destination register |
| iss_grant | output | 1 | Group accepted this cycle |
| iss_tag | output | ISSUE_W*TW | Per lane allocated buffer tag |
| src_areg | input | ISSUE_W*AW | Per lane source register to look up |
| src_arch_data | input | ISSUE_W*DW | Architectural file value of each looked-up register |
| src_ready | output | ISSUE_W | Per lane operand value available |
| src_tag | output | ISSUE_W*TW | Per lane producing buffer when not ready |
| src_data | output | ISSUE_W*DW | Per lane operand value when ready |
| alu_we | input | NUM_ALU | Integer unit result valid |
| alu_tag | input | NUM_ALU*TW | Integer unit result buffer |
| alu_data | input | NUM_ALU*DW | Integer unit result value |
| lsu_we | input | 1 | Load data result valid |
| lsu_tag | input | TW | Load data buffer |
| lsu_data | input | DW | Loaded value |
| lsu_upd_we | input | 1 | Updated address result valid |
| lsu_upd_tag | input | TW | Updated address buffer |
| lsu_upd_data | input | DW | Updated address value |
| ret_cnt | output | $clog2(RET_W+1) | Buffers retiring at the next edge |
| ret_we | output | RET_W | Per lane architectural write enable |
| ret_areg | output | RET_W*AW | Per lane architectural register |
| ret_data | output | RET_W*DW | Per lane value to write |

## Verification
The bench completes the youngest results of a group before the oldest. A design that retired past a pending buffer would then report a nonzero `ret_cnt`, or deliver values to the scoreboard out of order. It makes eight buffers ready at once, so a missing four-wide cap shows up as a retire count above four. It fills the pool completely and then requests one slot, and later requests three slots when only two are free, so an off-by-one in the free count would grant a stalled group or shift the later tags. It checks that intra-group lookups pick the newest earlier lane. It also replaces the architectural value after a retirement, so a mapping that is left stale, or one cleared although a newer buffer owns the register, is exposed through the lookup data or tag.

// File: rtl/rnm_pkg.sv
package rnm_pkg;
  localparam int DEF_AREGS = 16;
  localparam int DEF_BUFS  = 16;
  localparam int DEF_DW    = 32;
  localparam int DEF_ISSUE = 4;
  localparam int DEF_RET   = 4;
  localparam int DEF_ALUS  = 2;

  typedef enum logic [1:0] {SRC_ARCH, SRC_BUF_DONE, SRC_BUF_WAIT} src_kind_e;

  // circular index advance; offset never exceeds the modulus
  function automatic int wrap_add(input int base, input int off, input int modulus);
    int s;
    s = base + off;
    if (s >= modulus) s = s - modulus;
    return s;
  endfunction
endpackage

// File: rtl/rnm_queue_ctl.sv
module rnm_queue_ctl
  import rnm_pkg::*;
#(
  parameter int NUM_BUF = DEF_BUFS,
  parameter int ISSUE_W = DEF_ISSUE,
  parameter int RET_W   = DEF_RET,
  localparam int TW  = $clog2(NUM_BUF),
  localparam int OW  = $clog2(NUM_BUF + 1),
  localparam int CW  = $clog2(ISSUE_W + 1),
  localparam int RCW = $clog2(RET_W + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [CW-1:0]  iss_cnt,
  input  logic [RCW-1:0] ret_cnt,
  output logic           grant,
  output logic [ISSUE_W-1:0] lane_req,
  output logic [ISSUE_W-1:0] lane_alloc,
  output logic [TW-1:0]  alloc_tag [ISSUE_W],
  output logic [TW-1:0]  head,
  output logic [OW-1:0]  occ
);
  logic [TW-1:0] head_q, head_d, tail_q, tail_d;
  logic [OW-1:0] occ_q, occ_d;
  int free_slots, n_alloc;

  always_comb begin
    free_slots = NUM_BUF - int'(occ_q);
    grant      = (int'(iss_cnt) <= ISSUE_W) && (int'(iss_cnt) <= free_slots);
    n_alloc    = grant ? int'(iss_cnt) : 0;
    for (int i = 0; i < ISSUE_W; i++) begin
      lane_req[i]   = (i < int'(iss_cnt));
      lane_alloc[i] = grant && lane_req[i];
      alloc_tag[i]  = TW'(wrap_add(int'(tail_q), i, NUM_BUF));
    end
    tail_d = TW'(wrap_add(int'(tail_q), n_alloc, NUM_BUF));
    head_d = TW'(wrap_add(int'(head_q), int'(ret_cnt), NUM_BUF));
    occ_d  = OW'(int'(occ_q) + n_alloc - int'(ret_cnt));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      occ_q  <= '0;
    end else begin
      if (n_alloc != 0) tail_q <= tail_d;
      if (ret_cnt != '0) head_q <= head_d;
      if (n_alloc != 0 || ret_cnt != '0) occ_q <= occ_d;
    end
  end

  assign head = head_q;
  assign occ  = occ_q;

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(occ_q) <= NUM_BUF);
  assert_ret_within_occ_R7: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ret_cnt) <= int'(occ_q));
  assert_iss_cnt_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(iss_cnt) <= ISSUE_W);
endmodule

// File: rtl/rnm_buf_pool.sv
module rnm_buf_pool
  import rnm_pkg::*;
#(
  parameter int NUM_BUF  = DEF_BUFS,
  parameter int NUM_AREG = DEF_AREGS,
  parameter int DW       = DEF_DW,
  parameter int ISSUE_W  = DEF_ISSUE,
  parameter int RET_W    = DEF_RET,
  parameter int NWP      = DEF_ALUS + 2,
  localparam int TW  = $clog2(NUM_BUF),
  localparam int AW  = $clog2(NUM_AREG),
  localparam int OW  = $clog2(NUM_BUF + 1),
  localparam int RCW = $clog2(RET_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ISSUE_W-1:0] lane_alloc,
  input  logic [TW-1:0]      alloc_tag [ISSUE_W],
  input  logic [ISSUE_W-1:0] alloc_has_dst,
  input  logic [AW-1:0]      alloc_dst [ISSUE_W],
  input  logic [NWP-1:0]     wp_we,
  input  logic [TW-1:0]      wp_tag  [NWP],
  input  logic [DW-1:0]      wp_data [NWP],
  input  logic [TW-1:0]      head,
  input  logic [OW-1:0]      occ,
  input  logic [TW-1:0]      rd_tag  [ISSUE_W],
  output logic [ISSUE_W-1:0] rd_done,
  output logic [DW-1:0]      rd_data [ISSUE_W],
  output logic [RCW-1:0]     ret_cnt,
  output logic [RET_W-1:0]   ret_we,
  output logic [TW-1:0]      ret_tag  [RET_W],
  output logic [AW-1:0]      ret_areg [RET_W],
  output logic [DW-1:0]      ret_data [RET_W]
);
  logic [NUM_BUF-1:0] res_q, res_d;
  logic [NUM_BUF-1:0] hasd_q;
  logic [AW-1:0]      dst_q  [NUM_BUF];
  logic [DW-1:0]      data_q [NUM_BUF];
  logic [RET_W-1:0]   ret_take;

  // oldest-first scan: stop at the first buffer without its result
  always_comb begin
    logic stop;
    int   cnt;
    stop = 1'b0;
    cnt  = 0;
    for (int j = 0; j < RET_W; j++) begin
      ret_tag[j]  = TW'(wrap_add(int'(head), j, NUM_BUF));
      ret_take[j] = 1'b0;
      if (!stop && (j < int'(occ)) && res_q[ret_tag[j]]) begin
        ret_take[j] = 1'b1;
        cnt = cnt + 1;
      end else begin
        stop = 1'b1;
      end
      ret_we[j]   = ret_take[j] && hasd_q[ret_tag[j]];
      ret_areg[j] = dst_q[ret_tag[j]];
      ret_data[j] = data_q[ret_tag[j]];
    end
    ret_cnt = RCW'(cnt);
  end

  always_comb begin
    res_d = res_q;
    for (int j = 0; j < RET_W; j++)
      if (ret_take[j]) res_d[ret_tag[j]] = 1'b0;
    for (int i = 0; i < ISSUE_W; i++)
      if (lane_alloc[i]) res_d[alloc_tag[i]] = 1'b0;
    for (int p = 0; p < NWP; p++)
      if (wp_we[p]) res_d[wp_tag[p]] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) res_q <= '0;
    else        res_q <= res_d;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ISSUE_W; i++) begin
      if (lane_alloc[i]) begin
        hasd_q[alloc_tag[i]] <= alloc_has_dst[i];
        dst_q[alloc_tag[i]]  <= alloc_dst[i];
      end
    end
    for (int p = 0; p < NWP; p++)
      if (wp_we[p]) data_q[wp_tag[p]] <= wp_data[p];
  end

  always_comb begin
    for (int i = 0; i < ISSUE_W; i++) begin
      rd_done[i] = res_q[rd_tag[i]];
      rd_data[i] = data_q[rd_tag[i]];
    end
  end

  function automatic logic tag_live(input logic [TW-1:0] t, input logic [TW-1:0] h,
                                    input logic [OW-1:0] n);
    int off;
    off = int'(t) - int'(h);
    if (off < 0) off = off + NUM_BUF;
    return off < int'(n);
  endfunction

  for (genvar p = 0; p < NWP; p++) begin : g_wp_chk
    assert_wp_live_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wp_we[p] |-> tag_live(wp_tag[p], head, occ));
    for (genvar q = p + 1; q < NWP; q++) begin : g_pair
      assert_wp_distinct_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(wp_we[p] && wp_we[q] && (wp_tag[p] == wp_tag[q])));
    end
  end
endmodule

// File: rtl/rnm_map_table.sv
module rnm_map_table
  import rnm_pkg::*;
#(
  parameter int NUM_AREG = DEF_AREGS,
  parameter int NUM_BUF  = DEF_BUFS,
  parameter int DW       = DEF_DW,
  parameter int ISSUE_W  = DEF_ISSUE,
  parameter int RET_W    = DEF_RET,
  localparam int TW = $clog2(NUM_BUF),
  localparam int AW = $clog2(NUM_AREG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ISSUE_W-1:0] lane_req,
  input  logic [ISSUE_W-1:0] lane_alloc,
  input  logic [TW-1:0]      alloc_tag [ISSUE_W],
  input  logic [ISSUE_W-1:0] alloc_has_dst,
  input  logic [AW-1:0]      alloc_dst [ISSUE_W],
  input  logic [RET_W-1:0]   ret_we,
  input  logic [TW-1:0]      ret_tag  [RET_W],
  input  logic [AW-1:0]      ret_areg [RET_W],
  input  logic [AW-1:0]      src_areg [ISSUE_W],
  input  logic [DW-1:0]      src_arch [ISSUE_W],
  output logic [TW-1:0]      rd_tag   [ISSUE_W],
  input  logic [ISSUE_W-1:0] rd_done,
  input  logic [DW-1:0]      rd_data  [ISSUE_W],
  output logic [ISSUE_W-1:0] src_ready,
  output logic [TW-1:0]      src_tag  [ISSUE_W],
  output logic [DW-1:0]      src_data [ISSUE_W]
);
  logic [NUM_AREG-1:0] map_v_q, map_v_d;
  logic [TW-1:0]       map_t_q [NUM_AREG];
  logic [TW-1:0]       map_t_d [NUM_AREG];
  logic [NUM_AREG-1:0] map_t_en;

  // retirement clears stale entries first, then issue lanes claim in order
  always_comb begin
    map_v_d  = map_v_q;
    map_t_d  = map_t_q;
    map_t_en = '0;
    for (int j = 0; j < RET_W; j++)
      if (ret_we[j] && map_v_q[ret_areg[j]] && (map_t_q[ret_areg[j]] == ret_tag[j]))
        map_v_d[ret_areg[j]] = 1'b0;
    for (int i = 0; i < ISSUE_W; i++) begin
      if (lane_alloc[i] && alloc_has_dst[i]) begin
        map_v_d[alloc_dst[i]]  = 1'b1;
        map_t_d[alloc_dst[i]]  = alloc_tag[i];
        map_t_en[alloc_dst[i]] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) map_v_q <= '0;
    else        map_v_q <= map_v_d;
  end

  always_ff @(posedge clk) begin
    for (int a = 0; a < NUM_AREG; a++)
      if (map_t_en[a]) map_t_q[a] <= map_t_d[a];
  end

  always_comb begin
    for (int i = 0; i < ISSUE_W; i++) rd_tag[i] = map_t_q[src_areg[i]];
  end

  always_comb begin
    src_kind_e kind;
    logic [TW-1:0] tag;
    for (int i = 0; i < ISSUE_W; i++) begin
      if (!map_v_q[src_areg[i]]) begin
        kind = SRC_ARCH;
        tag  = '0;
      end else begin
        kind = rd_done[i] ? SRC_BUF_DONE : SRC_BUF_WAIT;
        tag  = rd_tag[i];
      end
      for (int j = 0; j < ISSUE_W; j++) begin
        if (j < i && lane_req[j] && alloc_has_dst[j] && (alloc_dst[j] == src_areg[i])) begin
          kind = SRC_BUF_WAIT;
          tag  = alloc_tag[j];
        end
      end
      src_tag[i] = tag;
      unique case (kind)
        SRC_ARCH:     begin src_ready[i] = 1'b1; src_data[i] = src_arch[i]; end
        SRC_BUF_DONE: begin src_ready[i] = 1'b1; src_data[i] = rd_data[i];  end
        default:      begin src_ready[i] = 1'b0; src_data[i] = '0;          end
      endcase
    end
  end

  localparam int LAST = ISSUE_W - 1;
  assert_map_newest_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_alloc[LAST] && alloc_has_dst[LAST]) |=>
      (map_v_q[$past(alloc_dst[LAST])] && (map_t_q[$past(alloc_dst[LAST])] == $past(alloc_tag[LAST]))));
endmodule

// File: rtl/rnm_unit.sv
module rnm_unit
  import rnm_pkg::*;
#(
  parameter int NUM_AREG = DEF_AREGS,
  parameter int NUM_BUF  = DEF_BUFS,
  parameter int DW       = DEF_DW,
  parameter int ISSUE_W  = DEF_ISSUE,
  parameter int RET_W    = DEF_RET,
  parameter int NUM_ALU  = DEF_ALUS,
  localparam int AW  = $clog2(NUM_AREG),
  localparam int TW  = $clog2(NUM_BUF),
  localparam int OW  = $clog2(NUM_BUF + 1),
  localparam int CW  = $clog2(ISSUE_W + 1),
  localparam int RCW = $clog2(RET_W + 1),
  localparam int NWP = NUM_ALU + 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [CW-1:0]         iss_cnt,
  input  logic [ISSUE_W-1:0]    iss_has_dst,
  input  logic [ISSUE_W*AW-1:0] iss_dst,
  output logic                  iss_grant,
  output logic [ISSUE_W*TW-1:0] iss_tag,
  input  logic [ISSUE_W*AW-1:0] src_areg,
  input  logic [ISSUE_W*DW-1:0] src_arch_data,
  output logic [ISSUE_W-1:0]    src_ready,
  output logic [ISSUE_W*TW-1:0] src_tag,
  output logic [ISSUE_W*DW-1:0] src_data,
  input  logic [NUM_ALU-1:0]    alu_we,
  input  logic [NUM_ALU*TW-1:0] alu_tag,
  input  logic [NUM_ALU*DW-1:0] alu_data,
  input  logic                  lsu_we,
  input  logic [TW-1:0]         lsu_tag,
  input  logic [DW-1:0]         lsu_data,
  input  logic                  lsu_upd_we,
  input  logic [TW-1:0]         lsu_upd_tag,
  input  logic [DW-1:0]         lsu_upd_data,
  output logic [RCW-1:0]        ret_cnt,
  output logic [RET_W-1:0]      ret_we,
  output logic [RET_W*AW-1:0]   ret_areg,
  output logic [RET_W*DW-1:0]   ret_data
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [ISSUE_W-1:0] lane_req, lane_alloc;
  logic [TW-1:0]      alloc_tag [ISSUE_W];
  logic [AW-1:0]      dst_a [ISSUE_W];
  logic [AW-1:0]      srca_a [ISSUE_W];
  logic [DW-1:0]      arch_a [ISSUE_W];
  logic [TW-1:0]      rd_tag [ISSUE_W];
  logic [ISSUE_W-1:0] rd_done;
  logic [DW-1:0]      rd_data [ISSUE_W];
  logic [TW-1:0]      stag_a [ISSUE_W];
  logic [DW-1:0]      sdata_a [ISSUE_W];
  logic [NWP-1:0]     wp_we;
  logic [TW-1:0]      wp_tag  [NWP];
  logic [DW-1:0]      wp_data [NWP];
  logic [TW-1:0]      head;
  logic [OW-1:0]      occ;
  logic [TW-1:0]      rt_tag  [RET_W];
  logic [AW-1:0]      rt_areg [RET_W];
  logic [DW-1:0]      rt_data [RET_W];

  for (genvar g = 0; g < ISSUE_W; g++) begin : g_lane
    assign dst_a[g]  = iss_dst[g*AW +: AW];
    assign srca_a[g] = src_areg[g*AW +: AW];
    assign arch_a[g] = src_arch_data[g*DW +: DW];
    assign iss_tag[g*TW +: TW]  = alloc_tag[g];
    assign src_tag[g*TW +: TW]  = stag_a[g];
    assign src_data[g*DW +: DW] = sdata_a[g];
  end

  for (genvar g = 0; g < NUM_ALU; g++) begin : g_alu
    assign wp_we[g]   = alu_we[g];
    assign wp_tag[g]  = alu_tag[g*TW +: TW];
    assign wp_data[g] = alu_data[g*DW +: DW];
  end
  assign wp_we[NUM_ALU]     = lsu_we;
  assign wp_tag[NUM_ALU]    = lsu_tag;
  assign wp_data[NUM_ALU]   = lsu_data;
  assign wp_we[NUM_ALU+1]   = lsu_upd_we;
  assign wp_tag[NUM_ALU+1]  = lsu_upd_tag;
  assign wp_data[NUM_ALU+1] = lsu_upd_data;

  for (genvar g = 0; g < RET_W; g++) begin : g_ret
    assign ret_areg[g*AW +: AW] = rt_areg[g];
    assign ret_data[g*DW +: DW] = rt_data[g];
  end

  rnm_queue_ctl #(.NUM_BUF(NUM_BUF), .ISSUE_W(ISSUE_W), .RET_W(RET_W)) i_qctl (
    .clk(clk), .rst_n(rst_int_n), .iss_cnt(iss_cnt), .ret_cnt(ret_cnt),
    .grant(iss_grant), .lane_req(lane_req), .lane_alloc(lane_alloc),
    .alloc_tag(alloc_tag), .head(head), .occ(occ));

  rnm_buf_pool #(.NUM_BUF(NUM_BUF), .NUM_AREG(NUM_AREG), .DW(DW), .ISSUE_W(ISSUE_W),
                 .RET_W(RET_W), .NWP(NWP)) i_pool (
    .clk(clk), .rst_n(rst_int_n), .lane_alloc(lane_alloc), .alloc_tag(alloc_tag),
    .alloc_has_dst(iss_has_dst), .alloc_dst(dst_a), .wp_we(wp_we), .wp_tag(wp_tag),
    .wp_data(wp_data), .head(head), .occ(occ), .rd_tag(rd_tag), .rd_done(rd_done),
    .rd_data(rd_data), .ret_cnt(ret_cnt), .ret_we(ret_we), .ret_tag(rt_tag),
    .ret_areg(rt_areg), .ret_data(rt_data));

  rnm_map_table #(.NUM_AREG(NUM_AREG), .NUM_BUF(NUM_BUF), .DW(DW), .ISSUE_W(ISSUE_W),
                  .RET_W(RET_W)) i_map (
    .clk(clk), .rst_n(rst_int_n), .lane_req(lane_req), .lane_alloc(lane_alloc),
    .alloc_tag(alloc_tag), .alloc_has_dst(iss_has_dst), .alloc_dst(dst_a),
    .ret_we(ret_we), .ret_tag(rt_tag), .ret_areg(rt_areg), .src_areg(srca_a),
    .src_arch(arch_a), .rd_tag(rd_tag), .rd_done(rd_done), .rd_data(rd_data),
    .src_ready(src_ready), .src_tag(stag_a), .src_data(sdata_a));
endmodule

// File: tb/test_rnm_unit.sv
module test_rnm_unit;
  localparam int AW = 4, TW = 4, DW = 32, IW = 4, RW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [2:0]     iss_cnt = '0;
  logic [IW-1:0]  iss_has_dst = '0;
  logic [IW*AW-1:0] iss_dst = '0;
  logic           iss_grant;
  logic [IW*TW-1:0] iss_tag;
  logic [IW*AW-1:0] src_areg = '0;
  logic [IW*DW-1:0] src_arch_data;
  logic [IW-1:0]  src_ready;
  logic [IW*TW-1:0] src_tag;
  logic [IW*DW-1:0] src_data;
  logic [1:0]     alu_we = '0;
  logic [2*TW-1:0] alu_tag = '0;
  logic [2*DW-1:0] alu_data = '0;
  logic lsu_we = 1'b0, lsu_upd_we = 1'b0;
  logic [TW-1:0] lsu_tag = '0, lsu_upd_tag = '0;
  logic [DW-1:0] lsu_data = '0, lsu_upd_data = '0;
  logic [2:0]     ret_cnt;
  logic [RW-1:0]  ret_we;
  logic [RW*AW-1:0] ret_areg;
  logic [RW*DW-1:0] ret_data;

  logic [DW-1:0] arch_m [16];
  logic [DW-1:0] val_of_tag [16];
  typedef struct { logic [AW-1:0] a; logic [DW-1:0] d; } exp_t;
  exp_t exp_q [$];
  int n_chk = 0, n_bad = 0, seq = 0;
  bit done = 0;

  for (genvar g = 0; g < IW; g++) begin : g_arch
    assign src_arch_data[g*DW +: DW] = arch_m[src_areg[g*AW +: AW]];
  end

  rnm_unit i_rnm_unit (.*);

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  // monitor: pop expected retirements in order
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int j = 0; j < RW; j++) begin
        if (ret_we[j]) begin
          if (exp_q.size() == 0) chk("R7 unexpected retire", 32'(ret_areg[j*AW +: AW]), 32'hFFFF_FFFF);
          else begin
            exp_t e;
            e = exp_q.pop_front();
            chk("R7 retire register", 32'(ret_areg[j*AW +: AW]), 32'(e.a));
            chk("R6 retire value", ret_data[j*DW +: DW], e.d);
            arch_m[ret_areg[j*AW +: AW]] = ret_data[j*DW +: DW];
          end
        end
      end
    end
  end

  // drive a group, check grant and tags; record expected results
  task automatic iss_set(input int cnt, input logic [3:0] hd, input logic [15:0] dsts, input bit exp_g);
    iss_cnt = 3'(cnt); iss_has_dst = hd; iss_dst = dsts;
    #1;
    chk("R3 grant", 32'(iss_grant), 32'(exp_g));
    if (exp_g) begin
      for (int i = 0; i < cnt; i++) begin
        chk("R2 tag", 32'(iss_tag[i*TW +: TW]), 32'((seq + i) % 16));
        val_of_tag[(seq + i) % 16] = 32'hC000_0000 + 32'(seq + i) * 32'h0101;
        if (hd[i]) exp_q.push_back('{a: dsts[i*4 +: 4], d: 32'hC000_0000 + 32'(seq + i) * 32'h0101});
      end
      seq = seq + cnt;
    end
  endtask

  task automatic iss_done();
    tick();
    iss_cnt = '0; iss_has_dst = '0; iss_dst = '0;
  endtask

  task automatic wr4(input logic [3:0] en, input logic [3:0] t0, t1, t2, t3);
    alu_we = en[1:0];
    alu_tag = {t1, t0};
    alu_data = {val_of_tag[t1], val_of_tag[t0]};
    lsu_we = en[2]; lsu_tag = t2; lsu_data = val_of_tag[t2];
    lsu_upd_we = en[3]; lsu_upd_tag = t3; lsu_upd_data = val_of_tag[t3];
    tick();
    alu_we = '0; lsu_we = 1'b0; lsu_upd_we = 1'b0;
    #1;
  endtask

  task automatic look(input int lane, input logic [3:0] r);
    src_areg[lane*AW +: AW] = r;
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    chk("watchdog expired", 32'd1, 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) arch_m[i] = 32'h0A00_0000 + 32'(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: empty after reset
    look(0, 4'd5); #1;
    chk("R1 ret_cnt", 32'(ret_cnt), 32'd0);
    chk("R1 ready", 32'(src_ready[0]), 32'd1);
    chk("R1 arch data", src_data[31:0], 32'h0A00_0005);

    // group: r1, none, r1, r2 ; tags 0..3
    look(0, 4'd5); look(1, 4'd1); look(2, 4'd7); look(3, 4'd1);
    iss_set(4, 4'b1101, {4'd2, 4'd1, 4'd0, 4'd1}, 1'b1);
    chk("R5 bypass lane1 ready", 32'(src_ready[1]), 32'd0);
    chk("R5 bypass lane1 tag", 32'(src_tag[1*TW +: TW]), 32'd0);
    chk("R5 newest lane3 tag", 32'(src_tag[3*TW +: TW]), 32'd2);
    chk("R4 unmapped ready", 32'(src_ready[0]), 32'd1);
    chk("R4 unmapped data", src_data[31:0], 32'h0A00_0005);
    iss_done();

    look(0, 4'd1); look(1, 4'd2); #1;
    chk("R10 r1 ready", 32'(src_ready[0]), 32'd0);
    chk("R10 r1 tag newest", 32'(src_tag[0 +: TW]), 32'd2);
    chk("R4 r2 wait tag", 32'(src_tag[1*TW +: TW]), 32'd3);

    wr4(4'b0011, 4'd2, 4'd3, 4'd0, 4'd0);
    chk("R7 stop at pending", 32'(ret_cnt), 32'd0);
    chk("R4 done ready", 32'(src_ready[0]), 32'd1);
    chk("R4 done data", src_data[31:0], val_of_tag[2]);

    wr4(4'b1100, 4'd0, 4'd0, 4'd0, 4'd1);
    chk("R7 ret_cnt four", 32'(ret_cnt), 32'd4);
    chk("R7 ret_we dst mask", 32'(ret_we), 32'b1101);
    tick();
    arch_m[1] = 32'h5EED_0001; #1;
    chk("R9 cleared r1 ready", 32'(src_ready[0]), 32'd1);
    chk("R9 cleared r1 data", src_data[31:0], 32'h5EED_0001);

    // R9: remapped register keeps newer mapping
    iss_set(1, 4'b0001, {12'd0, 4'd3}, 1'b1); iss_done();
    iss_set(1, 4'b0001, {12'd0, 4'd3}, 1'b1); iss_done();
    wr4(4'b0001, 4'd4, 4'd0, 4'd0, 4'd0);
    chk("R7 single retire", 32'(ret_cnt), 32'd1);
    tick();
    look(0, 4'd3); #1;
    chk("R9 newer kept ready", 32'(src_ready[0]), 32'd0);
    chk("R9 newer kept tag", 32'(src_tag[0 +: TW]), 32'd5);
    wr4(4'b0001, 4'd5, 4'd0, 4'd0, 4'd0);
    tick();
    arch_m[3] = 32'h5EED_0003; #1;
    chk("R9 cleared r3", src_data[31:0], 32'h5EED_0003);

    // fill pool, tags wrap
    iss_set(4, 4'b1111, {4'd11, 4'd10, 4'd9, 4'd8}, 1'b1); iss_done();
    iss_set(4, 4'b1111, {4'd15, 4'd14, 4'd13, 4'd12}, 1'b1); iss_done();
    iss_set(4, 4'b0110, {4'd0, 4'd9, 4'd8, 4'd0}, 1'b1); iss_done();
    iss_set(4, 4'b1111, {4'd4, 4'd5, 4'd6, 4'd7}, 1'b1); iss_done();
    iss_set(1, 4'b0001, {12'd0, 4'd9}, 1'b0); iss_done();   // R3 full pool
    wr4(4'b0011, 4'd6, 4'd7, 4'd0, 4'd0);
    chk("R7 partial retire", 32'(ret_cnt), 32'd2);
    tick();
    iss_set(3, 4'b0111, {4'd0, 4'd1, 4'd2, 4'd3}, 1'b0);   // R8 boundary: only 2 free
    iss_set(2, 4'b0011, {8'd0, 4'd11, 4'd10}, 1'b1);       // R8 granted, R3 tags 6,7
    iss_done();

    wr4(4'b1111, 4'd12, 4'd13, 4'd14, 4'd15);
    chk("R7 blocked by oldest", 32'(ret_cnt), 32'd0);
    wr4(4'b1111, 4'd8, 4'd9, 4'd10, 4'd11);
    chk("R7 capped at four", 32'(ret_cnt), 32'd4);
    tick();
    chk("R7 second batch", 32'(ret_cnt), 32'd4);
    wr4(4'b1111, 4'd0, 4'd1, 4'd2, 4'd3);
    wr4(4'b1111, 4'd4, 4'd5, 4'd6, 4'd7);
    tick(); tick(); #1;
    chk("R7 all retired", 32'(exp_q.size()), 32'd0);
    chk("R7 idle", 32'(ret_cnt), 32'd0);
    iss_cnt = 3'd4; #1;
    chk("R8 pool freed", 32'(iss_grant), 32'd1);
    iss_cnt = '0;

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule